// File: doc/BRIEF.md
# Address-Gated Serial Control Register

This block receives a control word for a frequency synthesizer over three wires: an active-low frame enable, a data line and a serial clock. All three wires are brought into the system clock domain through multi-flop synchronizers. Their edges are then detected there, so every register in the block runs on the single system clock.

While the enable is low, each rising edge of the serial clock takes one bit. The first two bits of a frame form an address. Only the pattern 1,1 allows the data bits that follow to enter a 19-bit shift register. When the enable rises after a valid address, the shift register is copied into a holding register, and an update strobe is raised for one cycle. The held word is decoded into the following outputs:

- two general-purpose outputs
- a two-bit reference-frequency select
- an AM/FM mode bit
- a 14-bit divide code, together with the divide ratio, which is that code plus one

Top module: `synth_ctrl_loader`

## Requirements
- R1: Serial-clock rising edges are counted only while `ser_en_n` is low. Edges that arrive while the enable is high shift nothing into the register and change no output.
- R2: The first two bits of a frame are an address. If they are not both 1, the frame loads nothing: `upd` stays low and all decoded outputs keep their values.
- R3: After a valid address, every further bit shifts in. When more than 19 data bits are sent, only the final 19 are kept.
- R4: The held word changes only in the cycle after the enable has risen, as seen in the system clock domain. While a frame is still open, the outputs show the previous word.
- R5: `out_gp[1]` is the last bit sent, `out_gp[0]` is the second-to-last bit, and `fm_mode` is the fifth-to-last bit.
- R6: `ref_sel[1]` is the fourth-to-last bit and `ref_sel[0]` is the third-to-last bit. The codes are 2'b11 for 20 kHz, 2'b10 for 10 kHz, 2'b01 for 9 kHz and 2'b00 for 1 kHz.
- R7: `div_code` is formed from the sixth-to-last through the nineteenth-to-last bits, with the nineteenth-to-last bit as the LSB. `div_ratio` equals `div_code` + 1, computed 15 bits wide.
- R8: The shift register is not cleared when a frame starts. After a valid frame of fewer than 19 data bits, the new bits occupy the top positions (the last bit is still the last-bit field), and the older contents move down toward the LSB.
- R9: `upd` is high for exactly one system cycle per valid frame, in the cycle in which the new outputs first appear.
- R10: Synchronous active-high `rst` clears the held word and the shift register, giving outputs of zero, `div_ratio` = 1 and `upd` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous to `clk` |
| ser_dat | input | 1 | Serial data |
| ser_en_n | input | 1 | Active-low frame enable |
| upd | output | 1 | One-cycle strobe when the held word loads |
| out_gp | output | 2 | General-purpose output bits |
| ref_sel | output | 2 | Reference-frequency select code |
| fm_mode | output | 1 | AM/FM mode bit |
| div_code | output | 14 | Loaded divide code |
| div_ratio | output | 15 | Effective divide ratio (code + 1) |

## Verification
The checker enforces the following on every cycle:

- the address counter never passes its limit
- the shift register moves only on a synchronized serial-clock edge inside an open frame that has a valid address
- a load occurs only on a detected enable rise after a valid address
- `upd` never lasts longer than one cycle
- the outputs hold whenever `upd` is low

Only the bench scenarios can show the data-dependent results. These are the field positions of each bit, the reference codes, discarding of surplus leading bits, the contents left behind by a short frame, the divide-ratio boundaries at codes 0 and 3FFF, and the fact that serial clocks sent while the enable is high leave no trace.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
   // positions of the raw serial wires inside the synchronizer vector
   localparam int SYN_CLK = 0;
   localparam int SYN_DAT = 1;
   localparam int SYN_EN  = 2;
   localparam int SYN_N   = 3;
   // idle levels: clock low, data low, enable deasserted (high)
   localparam logic [SYN_N-1:0] SYN_IDLE = 3'b100;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
   parameter int W = 3,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sctl_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) chain[s] <= RST_VAL;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sctl_frame.sv
module sctl_frame #(
   parameter int WORD_W = 19,
   parameter int ADDR_W = 2,
   parameter logic [ADDR_W-1:0] ADDR_VAL = '1,
   localparam int CNT_W = $clog2(ADDR_W + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sclk_rise,
   input  logic              en_fall,
   input  logic              s_active,
   input  logic              din,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              addr_ok,
   output logic [WORD_W-1:0] sr_q
);
   logic [ADDR_W-1:0] addr_sh;

   assign addr_ok = (cnt_q == CNT_W'(ADDR_W)) && (addr_sh == ADDR_VAL);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         addr_sh <= '0;
         sr_q    <= '0;
      end else if (en_fall) begin
         cnt_q   <= '0;
      end else if (sclk_rise && s_active) begin
         if (cnt_q < CNT_W'(ADDR_W)) begin
            cnt_q   <= cnt_q + 1'b1;
            if (ADDR_W > 1) addr_sh <= {addr_sh[(ADDR_W>1 ? ADDR_W-2 : 0):0], din};
            else            addr_sh <= ADDR_W'(din);
         end else if (addr_sh == ADDR_VAL) begin
            // newest bit enters at the top, oldest falls off the bottom
            sr_q <= {din, sr_q[WORD_W-1:1]};
         end
      end
   end
endmodule

// File: rtl/sctl_hold.sv
module sctl_hold #(
   parameter int WORD_W = 19,
   parameter int DIV_W  = 14
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [WORD_W-1:0] sr_q,
   output logic              upd,
   output logic [1:0]        out_gp,
   output logic [1:0]        ref_sel,
   output logic              fm_mode,
   output logic [DIV_W-1:0]  div_code,
   output logic [DIV_W:0]    div_ratio
);
   localparam int P_GP2 = WORD_W - 1;
   localparam int P_GP1 = WORD_W - 2;
   localparam int P_RB  = WORD_W - 3;
   localparam int P_RA  = WORD_W - 4;
   localparam int P_FM  = WORD_W - 5;

   logic [WORD_W-1:0] word_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         word_q <= '0;
         upd    <= 1'b0;
      end else begin
         upd <= load;
         if (load) word_q <= sr_q;
      end
   end

   assign out_gp    = {word_q[P_GP2], word_q[P_GP1]};
   assign ref_sel   = {word_q[P_RA], word_q[P_RB]};
   assign fm_mode   = word_q[P_FM];
   assign div_code  = word_q[DIV_W-1:0];
   assign div_ratio = {1'b0, div_code} + (DIV_W+1)'(1);
endmodule

// File: rtl/synth_ctrl_loader.sv
module synth_ctrl_loader #(
   parameter int WORD_W = 19,
   parameter int DIV_W  = 14,
   parameter int ADDR_W = 2,
   parameter logic [ADDR_W-1:0] ADDR_VAL = '1,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W = $clog2(ADDR_W + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ser_clk,
   input  logic             ser_dat,
   input  logic             ser_en_n,
   output logic             upd,
   output logic [1:0]       out_gp,
   output logic [1:0]       ref_sel,
   output logic             fm_mode,
   output logic [DIV_W-1:0] div_code,
   output logic [DIV_W:0]   div_ratio
);
   import sctl_pkg::*;

   if (WORD_W != DIV_W + 5) begin : g_bad_word
      $error("synth_ctrl_loader: WORD_W must equal DIV_W + 5");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("synth_ctrl_loader: ADDR_W must be at least 1");
   end

   logic [SYN_N-1:0] s_now, s_prev;
   logic sclk_rise, en_fall, en_rise, s_active, addr_ok, load;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] sr_q;

   sctl_sync #(.W(SYN_N), .STAGES(SYNC_STAGES), .RST_VAL(SYN_IDLE)) u_sync (
      .clk(clk), .rst(rst),
      .d({ser_en_n, ser_dat, ser_clk}),
      .q(s_now)
   );

   always_ff @(posedge clk) begin
      if (rst) s_prev <= SYN_IDLE;
      else     s_prev <= s_now;
   end

   assign sclk_rise = s_now[SYN_CLK] & ~s_prev[SYN_CLK];
   assign en_fall   = ~s_now[SYN_EN] &  s_prev[SYN_EN];
   assign en_rise   =  s_now[SYN_EN] & ~s_prev[SYN_EN];
   assign s_active  = ~s_now[SYN_EN];
   assign load      = en_rise & addr_ok;

   sctl_frame #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .ADDR_VAL(ADDR_VAL)) u_frame (
      .clk(clk), .rst(rst),
      .sclk_rise(sclk_rise), .en_fall(en_fall), .s_active(s_active),
      .din(s_now[SYN_DAT]),
      .cnt_q(cnt_q), .addr_ok(addr_ok), .sr_q(sr_q)
   );

   sctl_hold #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_hold (
      .clk(clk), .rst(rst), .load(load), .sr_q(sr_q),
      .upd(upd), .out_gp(out_gp), .ref_sel(ref_sel), .fm_mode(fm_mode),
      .div_code(div_code), .div_ratio(div_ratio)
   );
endmodule

// File: rtl/synth_ctrl_loader_chk.sv
module synth_ctrl_loader_chk #(
   parameter int WORD_W = 19,
   parameter int DIV_W  = 14,
   parameter int ADDR_W = 2,
   localparam int CNT_W = $clog2(ADDR_W + 1)
) (
   input logic              clk,
   input logic              rst,
   input logic              sclk_rise,
   input logic              en_rise,
   input logic              s_active,
   input logic              addr_ok,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [WORD_W-1:0] sr_q,
   input logic              upd,
   input logic [1:0]        out_gp,
   input logic [1:0]        ref_sel,
   input logic              fm_mode,
   input logic [DIV_W-1:0]  div_code
);
   // R2
   addr_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_W'(ADDR_W));

   // R1
   shift_gated_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(sr_q) |-> $past(sclk_rise && s_active && addr_ok));

   // R2
   load_needs_addr_chk: assert property (@(posedge clk) disable iff (rst)
      upd |-> $past(en_rise && addr_ok));

   // R9
   upd_single_chk: assert property (@(posedge clk) disable iff (rst)
      upd |=> !upd);

   // R4
   outputs_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !upd |-> $stable({out_gp, ref_sel, fm_mode, div_code}));
endmodule

bind synth_ctrl_loader synth_ctrl_loader_chk #(
   .WORD_W(WORD_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .en_rise(en_rise),
   .s_active(s_active), .addr_ok(addr_ok), .cnt_q(cnt_q), .sr_q(sr_q),
   .upd(upd), .out_gp(out_gp), .ref_sel(ref_sel), .fm_mode(fm_mode),
   .div_code(div_code)
);

// File: tb/synth_ctrl_loader_bench.sv
module synth_ctrl_loader_bench;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en_n = 1'b1;
   logic upd, fm_mode;
   logic [1:0] out_gp, ref_sel;
   logic [13:0] div_code;
   logic [14:0] div_ratio;

   int total = 0, bad = 0;
   bit done = 0;
   logic [18:0] exp_q[$];
   logic [18:0] m_sr = '0;
   logic [18:0] m_held = '0;
   bit upd_prev = 0;

   always #4 clk = ~clk;

   synth_ctrl_loader u_synth_ctrl_loader (
      .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en_n(ser_en_n),
      .upd(upd), .out_gp(out_gp), .ref_sel(ref_sel), .fm_mode(fm_mode),
      .div_code(div_code), .div_ratio(div_ratio)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // compare every decoded field against a 19-bit word (bit 18 = last bit sent)
   task automatic chk_word(input string tag, input logic [18:0] w);
      chk({tag, " R5 gp"},    32'(out_gp),    32'({w[18], w[17]}));
      chk({tag, " R6 ref"},   32'(ref_sel),   32'({w[15], w[16]}));
      chk({tag, " R5 fm"},    32'(fm_mode),   32'(w[14]));
      chk({tag, " R7 div"},   32'(div_code),  32'(w[13:0]));
      chk({tag, " R7 ratio"}, 32'(div_ratio), 32'(w[13:0]) + 32'd1);
   endtask

   // monitor: pops expected words as the design raises upd
   always @(negedge clk) begin
      if (!rst) begin
         if (upd && upd_prev) chk("R9 upd width", 32'd2, 32'd1);
         if (upd) begin
            if (exp_q.size() == 0) chk("R2 unexpected upd", 32'd1, 32'd0);
            else chk_word("R3 R4 load", exp_q.pop_front());
         end
         upd_prev = upd;
      end
   end

   task automatic ser_bit(input logic b);
      @(negedge clk) ser_dat = b;
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(negedge clk);
      ser_clk = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // driver: sends one frame, bits d[0] first, and pushes the expected word
   task automatic frame(input logic a1, input logic a0, input int n, input logic [31:0] d);
      bit ok = a1 & a0;
      @(negedge clk) ser_en_n = 1'b0;
      repeat (4) @(negedge clk);
      ser_bit(a1);
      ser_bit(a0);
      for (int i = 0; i < n; i++) begin
         ser_bit(d[i]);
         if (ok) m_sr = {d[i], m_sr[18:1]};
      end
      repeat (4) @(negedge clk);
      chk_word("R4 mid-frame", m_held);
      if (ok) begin
         m_held = m_sr;
         exp_q.push_back(m_sr);
      end
      ser_en_n = 1'b1;
      repeat (10) @(negedge clk);
      chk_word(ok ? "R3 after" : "R2 ignored", m_held);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R10 reset state
      chk("R10 upd", 32'(upd), 0);
      chk_word("R10 reset", 19'h0);

      frame(1, 1, 19, 32'h7ABCD);          // R6 code 11
      frame(1, 1, 25, 32'h1FF_28000);      // R3 surplus leading bits dropped
      frame(1, 0, 19, 32'h50000);          // R2 bad address
      frame(0, 1, 19, 32'h3FFFF);          // R2 bad address
      frame(1, 1, 19, 32'h50000);          // R6 code 01
      frame(1, 1, 19, 32'h21234);          // R6 code 00

      // R1: serial clocks with the enable high must leave no trace
      for (int i = 0; i < 5; i++) ser_bit(1'b1);
      chk_word("R1 idle clocks", m_held);
      frame(1, 1, 4, 32'h5);               // R8 short frame exposes old contents

      frame(1, 1, 19, 32'h03FFF);          // R7 ratio boundary 0x4000
      frame(1, 1, 19, 32'h00000);          // R7 ratio boundary 1

      chk("R9 all loads seen", 32'(exp_q.size()), 0);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule